// File: doc/BRIEF.md
# Debug Readout Byte Handshake

This block paces a stream of bytes from a slow firmware producer to an external host that runs its own transfer cycles. The producer places one byte in an 8-bit holding buffer and thereby raises a transmit-complete flag. Every host transfer strobe is answered on the next clock with a response strobe, a 2-bit status tag and a data byte. When the buffer holds fresh data, the byte goes out tagged as valid and the flag drops, which tells the producer it may load the next byte. When the producer falls behind, the host is told to retry with a busy tag.

A stream is opened by a start pulse and closed by an end-of-stream pulse from the producer. If the last byte is still waiting when the end pulse arrives, the block first delivers that byte and then falls back to idle. In idle, every transfer is answered with the idle tag, which tells the host that the engine can accept a new operation. Multi-byte values travel as separate bytes in the order they are loaded, so a 16-bit value is loaded and delivered low byte first.

Top module: `dbg_readout`

## Requirements
- R1: After reset the transmit-complete flag, the overrun flag and the response strobe are all 0, and the block is idle.
- R2: In idle, a producer write is ignored: the flag stays 0, and a following transfer is answered with status 2'b00 (idle) and byte 0.
- R3: During a stream, a producer write while the flag is 0 stores the byte and sets the flag on the next clock.
- R4: A transfer strobe while the flag is 1 yields, one clock later, a one-cycle response strobe with status 2'b11 (valid) and the stored byte, and the flag is 0 from that same clock.
- R5: A transfer strobe during a stream while the flag is 0 is answered with status 2'b01 (busy) and byte 0, and the flag is unchanged.
- R6: A producer write while the flag is 1 is rejected: the stored byte is unchanged, and the overrun flag goes to 1 and stays 1 until reset.
- R7: Bytes reach the host in load order, one per transfer, so a 16-bit value loaded low byte then high byte arrives low byte first.
- R8: An end-of-stream pulse while a byte is pending lets that byte be delivered as valid, and the transfer after it is answered with idle status 2'b00.
- R9: An end-of-stream pulse with no byte pending returns the block to idle at once, so the next transfer is answered with 2'b00.
- R10: A start pulse in idle opens a new stream, and the handshake works again after a previous stream has ended.
- R11: A write and a transfer in the same cycle are judged on the flag as it stood before that cycle. If the flag is 1, the old byte goes out and the write is rejected. If the flag is 0, the reply is busy and the write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse that opens a stream while idle |
| prod_wr | input | 1 | Producer write strobe for the holding buffer |
| prod_data | input | DATA_W | Byte written by the producer |
| prod_end | input | 1 | Producer end-of-stream pulse |
| txc_flag | output | 1 | Transmit-complete flag: buffer holds a byte not yet sent |
| ovr_flag | output | 1 | Sticky overrun: a write arrived while the flag was set |
| host_xfer | input | 1 | Host transfer-cycle strobe |
| host_vld | output | 1 | Response strobe, one clock after a transfer strobe |
| host_stat | output | 2 | Status tag: 00 idle, 01 busy, 11 valid |
| host_byte | output | DATA_W | Data byte, 0 unless the tag is valid |

## Verification
The handshake is driven with isolated writes followed by transfers, with transfers that arrive before any write, and with back-to-back writes. These patterns separate a valid reply from a busy reply and detect a lost or overwritten byte. Writes and transfers are also made to coincide with the flag both set and clear, which shows whether the decision uses the flag as it stood before the cycle. Ending a stream both with a byte pending and with nothing pending, and then restarting, shows whether a pending byte is dropped at the end and whether the idle tag appears at the right transfer.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;
   typedef enum logic [1:0] {
      STAT_IDLE  = 2'b00,
      STAT_BUSY  = 2'b01,
      STAT_VALID = 2'b11
   } stat_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'b00,
      PH_STREAM = 2'b01,
      PH_DRAIN  = 2'b10
   } phase_e;
endpackage

// File: rtl/dbg_rd_txbuf.sv
// Holding buffer with transmit-complete flag and sticky overrun.
module dbg_rd_txbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic [DATA_W-1:0] buf_q,
   output logic              txc,
   output logic              txc_nxt,
   output logic              ovr
);
   logic wr_ok, wr_rej, take_hit;

   assign wr_ok    = wr & ~txc & accept_en;
   assign wr_rej   = wr & txc;           // R6 rejected write
   assign take_hit = take & txc;

   always_comb begin
      txc_nxt = txc;
      if (wr_ok)         txc_nxt = 1'b1;  // R3
      else if (take_hit) txc_nxt = 1'b0;  // R4
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         txc   <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         txc <= txc_nxt;
         if (wr_ok)  buf_q <= wdata;
         if (wr_rej) ovr   <= 1'b1;
      end
   end
endmodule

// File: rtl/dbg_rd_seq.sv
// Stream phase sequencer: idle, streaming, draining the last byte.
module dbg_rd_seq
   import dbg_rd_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   stop,
   input  logic   take,
   input  logic   txc,
   input  logic   txc_nxt,
   output phase_e phase
);
   phase_e phase_d;

   always_comb begin
      phase_d = phase;
      unique case (phase)
         PH_IDLE:   if (start) phase_d = PH_STREAM;                 // R10
         PH_STREAM: if (stop)  phase_d = txc_nxt ? PH_DRAIN : PH_IDLE; // R8 R9
         PH_DRAIN:  if (take && txc) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_d;
   end
endmodule

// File: rtl/dbg_rd_resp.sv
// Registered host response: strobe, status tag and data byte.
module dbg_rd_resp
   import dbg_rd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              txc,
   input  phase_e            phase,
   input  logic [DATA_W-1:0] buf_q,
   output logic              vld,
   output logic [1:0]        stat,
   output logic [DATA_W-1:0] data
);
   stat_e tag;

   always_comb begin
      if (txc)                  tag = STAT_VALID;
      else if (phase == PH_IDLE) tag = STAT_IDLE;
      else                      tag = STAT_BUSY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         stat <= STAT_IDLE;
         data <= '0;
      end else begin
         vld <= take;
         if (take) begin
            stat <= tag;
            data <= txc ? buf_q : '0;
         end
      end
   end
endmodule

// File: rtl/dbg_readout.sv
module dbg_readout
   import dbg_rd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              prod_wr,
   input  logic [DATA_W-1:0] prod_data,
   input  logic              prod_end,
   output logic              txc_flag,
   output logic              ovr_flag,
   input  logic              host_xfer,
   output logic              host_vld,
   output logic [1:0]        host_stat,
   output logic [DATA_W-1:0] host_byte
);
   if (DATA_W != 8) begin : g_bad_width
      $error("dbg_readout: DATA_W must be 8");
   end

   logic [DATA_W-1:0] buf_q;
   logic              txc_q, txc_nxt;
   phase_e            phase;

   dbg_rd_txbuf #(.DATA_W(DATA_W)) u_txbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_en (phase == PH_STREAM),
      .wr        (prod_wr),
      .wdata     (prod_data),
      .take      (host_xfer),
      .buf_q     (buf_q),
      .txc       (txc_q),
      .txc_nxt   (txc_nxt),
      .ovr       (ovr_flag)
   );

   dbg_rd_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (op_start),
      .stop    (prod_end),
      .take    (host_xfer),
      .txc     (txc_q),
      .txc_nxt (txc_nxt),
      .phase   (phase)
   );

   dbg_rd_resp #(.DATA_W(DATA_W)) u_resp (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (host_xfer),
      .txc   (txc_q),
      .phase (phase),
      .buf_q (buf_q),
      .vld   (host_vld),
      .stat  (host_stat),
      .data  (host_byte)
   );

   assign txc_flag = txc_q;
endmodule

// File: rtl/dbg_readout_chk.sv
module dbg_readout_chk
   import dbg_rd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prod_wr,
   input logic              host_xfer,
   input logic              txc_flag,
   input logic              ovr_flag,
   input logic              host_vld,
   input logic [1:0]        host_stat,
   input logic [DATA_W-1:0] host_byte,
   input logic [DATA_W-1:0] buf_q,
   input phase_e            phase
);
   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prod_wr && !txc_flag && phase == PH_STREAM |=> txc_flag);

   p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_xfer && txc_flag |=> host_vld && host_stat == 2'b11
                                && host_byte == $past(buf_q) && !txc_flag);

   p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_xfer && !txc_flag && phase == PH_STREAM && !prod_wr
      |=> host_stat == 2'b01 && host_byte == '0 && !txc_flag);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);

   p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prod_wr && txc_flag && !host_xfer |=> $stable(buf_q) && ovr_flag);

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_xfer && phase == PH_IDLE |=> host_stat == 2'b00 && host_byte == '0);

   p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !host_xfer |=> !host_vld);
endmodule

bind dbg_readout dbg_readout_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prod_wr   (prod_wr),
   .host_xfer (host_xfer),
   .txc_flag  (txc_flag),
   .ovr_flag  (ovr_flag),
   .host_vld  (host_vld),
   .host_stat (host_stat),
   .host_byte (host_byte),
   .buf_q     (buf_q),
   .phase     (phase)
);

// File: tb/test_dbg_readout.sv
`timescale 1ns/100ps
module test_dbg_readout;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0, prod_wr = 1'b0, prod_end = 1'b0, host_xfer = 1'b0;
   logic [7:0] prod_data = '0;
   logic       txc_flag, ovr_flag, host_vld;
   logic [1:0] host_stat;
   logic [7:0] host_byte;
   int         n_cmp = 0, n_bad = 0, n_cyc = 0;

   always #2.5 clk = ~clk;

   dbg_readout i_dbg_readout (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .prod_wr(prod_wr),
      .prod_data(prod_data), .prod_end(prod_end), .txc_flag(txc_flag),
      .ovr_flag(ovr_flag), .host_xfer(host_xfer), .host_vld(host_vld),
      .host_stat(host_stat), .host_byte(host_byte)
   );

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // One clock with the given strobes held, then all strobes released.
   task automatic cyc(input logic st, input logic wr, input logic [7:0] d,
                      input logic en, input logic xf);
      op_start = st; prod_wr = wr; prod_data = d; prod_end = en; host_xfer = xf;
      @(posedge clk); #1;
      op_start = 0; prod_wr = 0; prod_end = 0; host_xfer = 0;
   endtask

   task automatic xfer_chk(input string req, input logic [1:0] st, input logic [7:0] b);
      cyc(0, 0, 8'h00, 0, 1);
      chk({req, " vld"}, host_vld, 1'b1);
      chk({req, " stat"}, host_stat, st);
      chk({req, " byte"}, host_byte, b);
   endtask

   task automatic t_reset_r1;
      rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1;
      chk("R1 txc", txc_flag, 0);
      chk("R1 ovr", ovr_flag, 0);
      chk("R1 vld", host_vld, 0);
      xfer_chk("R1 idle", 2'b00, 8'h00);
   endtask

   task automatic t_idle_write_r2;
      cyc(0, 1, 8'h5A, 0, 0);
      chk("R2 txc", txc_flag, 0);
      xfer_chk("R2 reply", 2'b00, 8'h00);
   endtask

   task automatic t_basic_r3_r4;
      cyc(1, 0, 8'h00, 0, 0);
      cyc(0, 1, 8'hA5, 0, 0);
      chk("R3 txc set", txc_flag, 1);
      xfer_chk("R4 valid", 2'b11, 8'hA5);
      chk("R4 txc clear", txc_flag, 0);
      cyc(0, 0, 8'h00, 0, 0);
      chk("R4 strobe one cycle", host_vld, 0);
   endtask

   task automatic t_busy_r5;
      xfer_chk("R5 busy", 2'b01, 8'h00);
      chk("R5 txc", txc_flag, 0);
   endtask

   task automatic t_word_r7;
      cyc(0, 1, 8'h34, 0, 0);
      xfer_chk("R7 low byte", 2'b11, 8'h34);
      cyc(0, 1, 8'h12, 0, 0);
      xfer_chk("R7 high byte", 2'b11, 8'h12);
   endtask

   task automatic t_overrun_r6;
      chk("R6 ovr before", ovr_flag, 0);
      cyc(0, 1, 8'h77, 0, 0);
      cyc(0, 1, 8'h88, 0, 0);
      chk("R6 ovr set", ovr_flag, 1);
      xfer_chk("R6 kept byte", 2'b11, 8'h77);
      cyc(0, 0, 8'h00, 0, 0);
      chk("R6 ovr sticky", ovr_flag, 1);
   endtask

   task automatic t_collide_r11;
      cyc(0, 1, 8'h55, 0, 0);
      cyc(0, 1, 8'h66, 0, 1);
      chk("R11 set: stat", host_stat, 2'b11);
      chk("R11 set: old byte", host_byte, 8'h55);
      chk("R11 set: write rejected", txc_flag, 0);
      cyc(0, 1, 8'h99, 0, 1);
      chk("R11 clear: busy", host_stat, 2'b01);
      chk("R11 clear: write taken", txc_flag, 1);
      xfer_chk("R11 clear: byte", 2'b11, 8'h99);
   endtask

   task automatic t_end_pending_r8;
      cyc(0, 1, 8'hC3, 0, 0);
      cyc(0, 0, 8'h00, 1, 0);
      chk("R8 txc held", txc_flag, 1);
      xfer_chk("R8 last byte", 2'b11, 8'hC3);
      xfer_chk("R8 then idle", 2'b00, 8'h00);
   endtask

   task automatic t_end_empty_r9;
      cyc(1, 0, 8'h00, 0, 0);
      xfer_chk("R9 streaming busy", 2'b01, 8'h00);
      cyc(0, 0, 8'h00, 1, 0);
      xfer_chk("R9 idle", 2'b00, 8'h00);
   endtask

   task automatic t_restart_r10;
      cyc(1, 0, 8'h00, 0, 0);
      cyc(0, 1, 8'h0F, 0, 0);
      xfer_chk("R10 restart", 2'b11, 8'h0F);
      rst_n = 0; @(posedge clk); #1; rst_n = 1;
      chk("R6 ovr cleared by reset", ovr_flag, 0);
   endtask

   initial begin
      t_reset_r1();
      t_idle_write_r2();
      t_basic_r3_r4();
      t_busy_r5();
      t_word_r7();
      t_overrun_r6();
      t_collide_r11();
      t_end_pending_r8();
      t_end_empty_r9();
      t_restart_r10();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule